// File: doc/BRIEF.md
# Edge-Triggered GPIO Bank with Atomic Set/Clear Aliases

This block is one bank of general-purpose pins on a simple 32-bit register bus: an address, a write strobe, write data and combinational read data. Every pin can be driven or sampled. A sampled pin can raise a sticky event when its input changes. Each pin selects its own edge with a 2-bit code. The codes for all pins are packed into two control words, eight pins per word.

Pin inputs pass through a two-flop synchronizer before any edge is detected. A selected edge latches a status bit whether or not that pin's interrupt is enabled. Software clears status bits by writing ones to them. Two outputs summarise the bank: an interrupt request and a wakeup request. The wakeup request is also gated by one bit of a configuration word.

Output data, interrupt enable and wakeup enable each have a write-one-to-set alias and a write-one-to-clear alias. Software can therefore change single bits without a read-modify-write sequence. Only edge triggers exist; there are no level-sensitive modes.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every pin is an input (`pin_oe` = 0), `pin_out` = 0, `irq_o` = 0 and `wake_o` = 0. The direction word at 0x34 reads 0xFFFF. Status (0x18), interrupt enable (0x1C) and both trigger words (0x38, 0x3C) read 0.
- R2: Direct writes to interrupt enable (0x1C), wakeup enable (0x28), output data (0x30) and direction (0x34) read back on bits 15:0, with upper bits reading 0. The configuration word at 0x10 stores and reads back only bit 2, the wakeup gate.
- R3: Address 0x00 reads the revision: major version in bits 7:4 and minor version in bits 3:0. With the default parameters it reads 0x21, and writes to it have no effect. Address 0x2C reads the synchronized pin inputs. A pin change shows there on the second rising clock edge after it.
- R4: A direction bit of 1 makes the pin an input (`pin_oe` bit 0). A direction bit of 0 drives the output-data bit on the pin (`pin_oe` bit 1). `pin_out` always equals the output-data register.
- R5: The aliases act on their target register: 0xDC/0x9C set/clear interrupt enable, 0xE8/0xA8 set/clear wakeup enable, 0xF0/0xB0 set/clear output data. Zero bits in an alias write leave the matching bits unchanged.
- R6: Pin p takes its 2-bit trigger code from bits [2*(p mod 8)+1 : 2*(p mod 8)]: pins 0-7 from the word at 0x38, pins 8-15 from the word at 0x3C. The codes are 00 none, 01 falling, 10 rising, 11 both edges. Only the selected edges set status.
- R7: A selected edge sets its status bit even when the pin's interrupt is disabled. The status bit becomes visible on the third rising clock edge after the pin changes.
- R8: Writing a 1 to a status bit clears it. Status bits written with 0 keep their value.
- R9: If a selected edge and a clearing write hit the same status bit on the same clock edge, the bit ends up set.
- R10: `irq_o` is high exactly when some status bit and its interrupt-enable bit are both 1.
- R11: `wake_o` is high exactly when configuration bit 2 is 1 and some status bit and its wakeup-enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one write per cycle while high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Asynchronous pin inputs |
| pin_out | output | 16 | Output data to the pins |
| pin_oe | output | 16 | Per-pin output enable, 1 = drive |
| irq_o | output | 1 | Bank interrupt request |
| wake_o | output | 1 | Bank wakeup request |

## Verification
The bench times each pin change against the synchronizer. It samples status one edge before and one edge after the expected edge, so a missing or an extra flop shows up as a wrong value. It places a clearing write on exactly the clock edge where a selected edge lands; a design where the clear wins would read the bit back as 0. Trigger codes are checked on pins in both words: a falling-only pin, a rising-only pin, a both-edges pin and a pin with no trigger. A swapped bit pair, or a word decoded at the wrong offset, would latch the wrong edge or none at all. The aliases are written with masks that leave some bits at 0, so a set or clear that overwrites the whole register changes bits it must keep.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   typedef enum logic [1:0] {
      TRIG_NONE = 2'b00,
      TRIG_FALL = 2'b01,
      TRIG_RISE = 2'b10,
      TRIG_BOTH = 2'b11
   } trig_e;

   localparam logic [7:0] OFS_REV      = 8'h00;
   localparam logic [7:0] OFS_CFG      = 8'h10;
   localparam logic [7:0] OFS_STAT     = 8'h18;
   localparam logic [7:0] OFS_IEN      = 8'h1C;
   localparam logic [7:0] OFS_WEN      = 8'h28;
   localparam logic [7:0] OFS_DIN      = 8'h2C;
   localparam logic [7:0] OFS_DOUT     = 8'h30;
   localparam logic [7:0] OFS_DIR      = 8'h34;
   localparam logic [7:0] OFS_TRIG_LO  = 8'h38;
   localparam logic [7:0] OFS_TRIG_HI  = 8'h3C;
   localparam logic [7:0] OFS_IEN_CLR  = 8'h9C;
   localparam logic [7:0] OFS_WEN_CLR  = 8'hA8;
   localparam logic [7:0] OFS_DOUT_CLR = 8'hB0;
   localparam logic [7:0] OFS_IEN_SET  = 8'hDC;
   localparam logic [7:0] OFS_WEN_SET  = 8'hE8;
   localparam logic [7:0] OFS_DOUT_SET = 8'hF0;

   localparam int CFG_WAKE_BIT  = 2;
   localparam int PINS_PER_WORD = 8;
   localparam int TRIG_BITS     = 2;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $fatal(1, "gpio_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= d;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg #(
   parameter int               WIDTH   = 16,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_full,
   input  logic             wr_set,
   input  logic             wr_clr,
   input  logic [WIDTH-1:0] wbits,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= RST_VAL;
      else if (wr_full) q <= wbits;
      else if (wr_set)  q <= q | wbits;
      else if (wr_clr)  q <= q & ~wbits;
   end

   p_set_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_set && !wr_full) |=> ((q & $past(wbits)) == $past(wbits)));

   p_clr_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && !wr_full && !wr_set) |=> ((q & $past(wbits)) == '0));

   p_zero_bits_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_set || wr_clr) && !wr_full) |=> ((q & ~$past(wbits)) == ($past(q) & ~$past(wbits))));

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_full && !wr_set && !wr_clr) |=> (q == $past(q)));

endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_PINS-1:0]           smp,
   input  logic [TRIG_BITS*NUM_PINS-1:0] trig_cfg,
   input  logic                          clr_wr,
   input  logic [NUM_PINS-1:0]           clr_mask,
   output logic [NUM_PINS-1:0]           status
);

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic  prev_q;
      logic  st_q;
      logic  rise;
      logic  fall;
      logic  hit;
      trig_e mode;

      assign mode = trig_e'(trig_cfg[TRIG_BITS*i +: TRIG_BITS]);
      assign rise = smp[i] & ~prev_q;
      assign fall = ~smp[i] & prev_q;

      always_comb begin
         hit = 1'b0;
         case (mode)
            TRIG_FALL: hit = fall;
            TRIG_RISE: hit = rise;
            TRIG_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            st_q   <= 1'b0;
         end else begin
            prev_q <= smp[i];
            if (hit)                      st_q <= 1'b1;
            else if (clr_wr && clr_mask[i]) st_q <= 1'b0;
         end
      end

      assign status[i] = st_q;

      p_rise_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (trig_cfg[TRIG_BITS*i+1] && $rose(smp[i])) |=> status[i]);

      p_fall_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (trig_cfg[TRIG_BITS*i] && $fell(smp[i])) |=> status[i]);

      p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_wr && clr_mask[i] && $stable(smp[i])) |=> !status[i]);

      p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_wr && clr_mask[i] && trig_cfg[TRIG_BITS*i+1] && $rose(smp[i])) |=> status[i]);

      p_no_trig_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (!status[i] && trig_cfg[TRIG_BITS*i +: TRIG_BITS] == TRIG_NONE) |=> !status[i]);
   end

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS  = 16,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int REV_MAJOR = 2,
   parameter int REV_MINOR = 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic                          bus_wr,
   input  logic [DATA_W-1:0]             bus_wdata,
   output logic [DATA_W-1:0]             bus_rdata,
   input  logic [NUM_PINS-1:0]           din,
   input  logic [NUM_PINS-1:0]           status,
   output logic [NUM_PINS-1:0]           dout_q,
   output logic [NUM_PINS-1:0]           dir_q,
   output logic [NUM_PINS-1:0]           ien_q,
   output logic [NUM_PINS-1:0]           wen_q,
   output logic                          wake_gate_q,
   output logic [TRIG_BITS*NUM_PINS-1:0] trig_q,
   output logic                          stat_clr_wr,
   output logic [NUM_PINS-1:0]           stat_clr_mask
);

   localparam int LO_PINS = (NUM_PINS < PINS_PER_WORD) ? NUM_PINS : PINS_PER_WORD;
   localparam int HI_PINS = NUM_PINS - LO_PINS;

   function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
      return a == ADDR_W'(ofs);
   endfunction

   logic [NUM_PINS-1:0] wbits;
   logic [DATA_W-1:0]   trig_lo_rd;
   logic [DATA_W-1:0]   trig_hi_rd;

   assign wbits         = bus_wdata[NUM_PINS-1:0];
   assign stat_clr_wr   = bus_wr && at(bus_addr, OFS_STAT);
   assign stat_clr_mask = wbits;

   gpio_alias_reg #(.WIDTH(NUM_PINS), .RST_VAL('0)) u_dout (
      .clk, .rst_n,
      .wr_full (bus_wr && at(bus_addr, OFS_DOUT)),
      .wr_set  (bus_wr && at(bus_addr, OFS_DOUT_SET)),
      .wr_clr  (bus_wr && at(bus_addr, OFS_DOUT_CLR)),
      .wbits, .q(dout_q));

   gpio_alias_reg #(.WIDTH(NUM_PINS), .RST_VAL('0)) u_ien (
      .clk, .rst_n,
      .wr_full (bus_wr && at(bus_addr, OFS_IEN)),
      .wr_set  (bus_wr && at(bus_addr, OFS_IEN_SET)),
      .wr_clr  (bus_wr && at(bus_addr, OFS_IEN_CLR)),
      .wbits, .q(ien_q));

   gpio_alias_reg #(.WIDTH(NUM_PINS), .RST_VAL('0)) u_wen (
      .clk, .rst_n,
      .wr_full (bus_wr && at(bus_addr, OFS_WEN)),
      .wr_set  (bus_wr && at(bus_addr, OFS_WEN_SET)),
      .wr_clr  (bus_wr && at(bus_addr, OFS_WEN_CLR)),
      .wbits, .q(wen_q));

   gpio_alias_reg #(.WIDTH(NUM_PINS), .RST_VAL({NUM_PINS{1'b1}})) u_dir (
      .clk, .rst_n,
      .wr_full (bus_wr && at(bus_addr, OFS_DIR)),
      .wr_set  (1'b0),
      .wr_clr  (1'b0),
      .wbits, .q(dir_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              wake_gate_q <= 1'b0;
      else if (bus_wr && at(bus_addr, OFS_CFG)) wake_gate_q <= bus_wdata[CFG_WAKE_BIT];
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_trig
      localparam logic [7:0] WORD_OFS = (p < PINS_PER_WORD) ? OFS_TRIG_LO : OFS_TRIG_HI;
      localparam int         FLD_LSB  = TRIG_BITS * (p % PINS_PER_WORD);
      logic [TRIG_BITS-1:0] fld_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 fld_q <= TRIG_NONE;
         else if (bus_wr && at(bus_addr, WORD_OFS)) fld_q <= bus_wdata[FLD_LSB +: TRIG_BITS];
      end

      assign trig_q[TRIG_BITS*p +: TRIG_BITS] = fld_q;
   end

   assign trig_lo_rd = DATA_W'(trig_q[TRIG_BITS*LO_PINS-1:0]);

   if (HI_PINS > 0) begin : g_hi_rd
      assign trig_hi_rd = DATA_W'(trig_q[TRIG_BITS*NUM_PINS-1:TRIG_BITS*LO_PINS]);
   end else begin : g_no_hi_rd
      assign trig_hi_rd = '0;
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFS_REV):     bus_rdata = DATA_W'({4'(REV_MAJOR), 4'(REV_MINOR)});
         ADDR_W'(OFS_CFG):     bus_rdata[CFG_WAKE_BIT] = wake_gate_q;
         ADDR_W'(OFS_STAT):    bus_rdata = DATA_W'(status);
         ADDR_W'(OFS_IEN):     bus_rdata = DATA_W'(ien_q);
         ADDR_W'(OFS_WEN):     bus_rdata = DATA_W'(wen_q);
         ADDR_W'(OFS_DIN):     bus_rdata = DATA_W'(din);
         ADDR_W'(OFS_DOUT):    bus_rdata = DATA_W'(dout_q);
         ADDR_W'(OFS_DIR):     bus_rdata = DATA_W'(dir_q);
         ADDR_W'(OFS_TRIG_LO): bus_rdata = trig_lo_rd;
         ADDR_W'(OFS_TRIG_HI): bus_rdata = trig_hi_rd;
         default:              bus_rdata = '0;
      endcase
   end

   p_cfg_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && at(bus_addr, OFS_CFG)) |=> (wake_gate_q == $past(bus_wdata[CFG_WAKE_BIT])));

   p_dir_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && at(bus_addr, OFS_DIR)) |=> $stable(dir_q));

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS    = 16,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int REV_MAJOR   = 2,
   parameter int REV_MINOR   = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                irq_o,
   output logic                wake_o
);

   if (NUM_PINS < 1 || NUM_PINS > 2*PINS_PER_WORD) begin : g_bad_pins
      $fatal(1, "gpio_edge_bank: NUM_PINS must be 1..16");
   end
   if (DATA_W < TRIG_BITS*PINS_PER_WORD) begin : g_bad_data
      $fatal(1, "gpio_edge_bank: DATA_W must hold eight trigger fields");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $fatal(1, "gpio_edge_bank: ADDR_W must be at least 8");
   end
   if (REV_MAJOR < 0 || REV_MAJOR > 15 || REV_MINOR < 0 || REV_MINOR > 15) begin : g_bad_rev
      $fatal(1, "gpio_edge_bank: revision fields are 4 bits");
   end

   logic [NUM_PINS-1:0]           din;
   logic [NUM_PINS-1:0]           status;
   logic [NUM_PINS-1:0]           dout_q;
   logic [NUM_PINS-1:0]           dir_q;
   logic [NUM_PINS-1:0]           ien_q;
   logic [NUM_PINS-1:0]           wen_q;
   logic                          wake_gate_q;
   logic [TRIG_BITS*NUM_PINS-1:0] trig_q;
   logic                          stat_clr_wr;
   logic [NUM_PINS-1:0]           stat_clr_mask;

   gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk, .rst_n, .d(pin_in), .q(din));

   gpio_regfile #(
      .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)
   ) u_regs (
      .clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rdata,
      .din, .status, .dout_q, .dir_q, .ien_q, .wen_q, .wake_gate_q,
      .trig_q, .stat_clr_wr, .stat_clr_mask);

   gpio_edge_unit #(.NUM_PINS(NUM_PINS)) u_edge (
      .clk, .rst_n, .smp(din), .trig_cfg(trig_q),
      .clr_wr(stat_clr_wr), .clr_mask(stat_clr_mask), .status);

   assign pin_out = dout_q;
   assign pin_oe  = ~dir_q;
   assign irq_o   = |(status & ien_q);
   assign wake_o  = wake_gate_q & (|(status & wen_q));

   p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !bus_wr) |=> irq_o);

   p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == '0) |-> !irq_o);

   p_wake_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_o && !bus_wr) |=> wake_o);

   p_wake_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !wake_gate_q |-> !wake_o);

endmodule

// File: tb/tb_gpio_edge_bank.sv
module tb_gpio_edge_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] pin_in = '0;
   logic [15:0] pin_out;
   logic [15:0] pin_oe;
   logic        irq_o;
   logic        wake_o;

   always #5 clk = ~clk;

   gpio_edge_bank dut (
      .clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rdata,
      .pin_in, .pin_out, .pin_oe, .irq_o, .wake_o);

   typedef struct {
      int          sel;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   event  mon_ev;
   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;

   function automatic logic [31:0] observe(int sel);
      case (sel)
         0:       return bus_rdata;
         1:       return {31'b0, irq_o};
         2:       return {31'b0, wake_o};
         3:       return {16'b0, pin_out};
         default: return {16'b0, pin_oe};
      endcase
   endfunction

   // monitor: pops expected items and compares against the design
   initial begin
      forever begin
         @(mon_ev);
         #1;
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = observe(it.sel);
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic expect_val(int sel, logic [31:0] exp, string tag);
      item_t it;
      it.sel = sel; it.exp = exp; it.tag = tag;
      q.push_back(it);
      -> mon_ev;
      #2;
   endtask

   task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
      bus_addr = a;
      expect_val(0, exp, tag);
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog: actual hang expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      expect_val(4, 32'h0, "R1 pin_oe after reset");
      expect_val(3, 32'h0, "R1 pin_out after reset");
      expect_val(1, 32'h0, "R1 irq after reset");
      expect_val(2, 32'h0, "R1 wake after reset");
      rd(8'h34, 32'h0000_FFFF, "R1 direction reset");
      rd(8'h18, 32'h0, "R1 status reset");
      rd(8'h1C, 32'h0, "R1 irq enable reset");
      rd(8'h38, 32'h0, "R1 trig lo reset");
      rd(8'h3C, 32'h0, "R1 trig hi reset");

      // R3 revision read-only
      rd(8'h00, 32'h21, "R3 revision");
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, 32'h21, "R3 revision after write");

      // R2 direct registers
      wr(8'h1C, 32'h1234_A5A5);
      rd(8'h1C, 32'h0000_A5A5, "R2 irq enable readback");
      wr(8'h28, 32'h0000_0F0F);
      rd(8'h28, 32'h0000_0F0F, "R2 wake enable readback");
      wr(8'h10, 32'hFFFF_FFFF);
      rd(8'h10, 32'h0000_0004, "R2 config stores bit 2 only");
      wr(8'h10, 32'h0);
      rd(8'h10, 32'h0, "R2 config cleared");

      // R4 direction and output data
      wr(8'h34, 32'h0000_FF00);
      expect_val(4, 32'h0000_00FF, "R4 pin_oe from direction");
      wr(8'h30, 32'h0000_00C3);
      expect_val(3, 32'h0000_00C3, "R4 pin_out from data");
      rd(8'h30, 32'h0000_00C3, "R2 data out readback");

      // R5 aliases
      wr(8'hF0, 32'h0000_0100);
      expect_val(3, 32'h0000_01C3, "R5 data set alias");
      wr(8'hB0, 32'h0000_0003);
      expect_val(3, 32'h0000_01C0, "R5 data clear alias");
      wr(8'hDC, 32'h0000_0002);
      rd(8'h1C, 32'h0000_A5A7, "R5 irq enable set alias");
      wr(8'h9C, 32'h0000_A5A5);
      rd(8'h1C, 32'h0000_0002, "R5 irq enable clear alias");
      wr(8'hE8, 32'h0000_8000);
      rd(8'h28, 32'h0000_8F0F, "R5 wake enable set alias");
      wr(8'hA8, 32'h0000_0F0F);
      rd(8'h28, 32'h0000_8000, "R5 wake enable clear alias");

      wr(8'h1C, 32'h0);
      wr(8'h28, 32'h0);
      wr(8'h34, 32'h0000_FFFF);

      // R6 trigger fields: pin0 fall, pin1 rise, pin8 both, pin15 rise
      wr(8'h38, 32'h0000_0009);
      wr(8'h3C, 32'h0000_8003);
      rd(8'h38, 32'h0000_0009, "R6 trig lo readback");
      rd(8'h3C, 32'h0000_8003, "R6 trig hi readback");

      // R3 data-in latency, R7 status latency
      pin_in = 16'h0003;
      tick(1);
      rd(8'h2C, 32'h0, "R3 data in after one edge");
      tick(1);
      rd(8'h2C, 32'h0000_0003, "R3 data in after two edges");
      rd(8'h18, 32'h0, "R7 status not yet set");
      tick(1);
      rd(8'h18, 32'h0000_0002, "R7 rise sets status without enable");
      expect_val(1, 32'h0, "R10 irq low with enable off");
      wr(8'h1C, 32'h0000_0002);
      expect_val(1, 32'h1, "R10 irq high when enabled");

      pin_in = 16'h0000;
      tick(3);
      rd(8'h18, 32'h0000_0003, "R6 falling code on pin0");

      // R8 write-one-to-clear
      wr(8'h18, 32'h0000_0001);
      rd(8'h18, 32'h0000_0002, "R8 clear bit0 keeps bit1");
      expect_val(1, 32'h1, "R10 irq still high");
      wr(8'h18, 32'h0000_0002);
      rd(8'h18, 32'h0, "R8 clear bit1");
      expect_val(1, 32'h0, "R10 irq low after clear");

      // R6 both edges on pin8
      pin_in = 16'h0100;
      tick(3);
      rd(8'h18, 32'h0000_0100, "R6 both code rise on pin8");
      wr(8'h18, 32'h0000_0100);
      pin_in = 16'h0000;
      tick(3);
      rd(8'h18, 32'h0000_0100, "R6 both code fall on pin8");
      wr(8'h18, 32'h0000_0100);

      // R6 rise-only on pin15 ignores fall
      pin_in = 16'h8000;
      tick(3);
      rd(8'h18, 32'h0000_8000, "R6 rising code on pin15");
      wr(8'h18, 32'h0000_8000);
      pin_in = 16'h0000;
      tick(3);
      rd(8'h18, 32'h0, "R6 rise-only ignores fall");

      // R6 no-trigger code on pin2
      pin_in = 16'h0004;
      tick(3);
      rd(8'h18, 32'h0, "R6 none code ignores edge");
      pin_in = 16'h0000;
      tick(3);

      // R9 event beats a same-edge clear
      pin_in = 16'h0002;
      tick(3);
      pin_in = 16'h0000;
      tick(3);
      rd(8'h18, 32'h0000_0002, "R9 setup status");
      pin_in = 16'h0002;
      tick(1);
      wr(8'h18, 32'h0000_0002);
      rd(8'h18, 32'h0000_0002, "R9 event wins over clear");
      wr(8'h18, 32'h0000_0002);
      rd(8'h18, 32'h0, "R8 clear alone");
      pin_in = 16'h0000;
      tick(3);

      // R11 wakeup gating
      pin_in = 16'h0002;
      tick(3);
      wr(8'h28, 32'h0000_0002);
      expect_val(2, 32'h0, "R11 wake gated off");
      wr(8'h10, 32'h0000_0004);
      expect_val(2, 32'h1, "R11 wake with gate on");
      wr(8'hA8, 32'h0000_0002);
      expect_val(2, 32'h0, "R11 wake off after enable clear");
      expect_val(1, 32'h1, "R10 irq independent of wake");
      wr(8'h9C, 32'h0000_0002);
      expect_val(1, 32'h0, "R10 irq off after enable clear");

      wr(8'h34, 32'h0);
      expect_val(4, 32'h0000_FFFF, "R4 all pins driven");

      #5;
      done = 1'b1;
      summary();
      $finish;
   end

endmodule